// File: doc/BRIEF.md
# Vectored Interrupt Controller with Master Enable

This block sits beside the CPU core of an 8-bit microcontroller and collects eleven interrupt sources. There are four external pins, four timer/counter channels, one A/D converter, one watchdog and one basic interval timer. Each source raises a sticky request flag with a one-cycle pulse. Each source also has its own enable bit. Both kinds of bit are reached through a byte-wide register bus, and the register bytes are split into a high byte and a low byte.

A fixed priority encoder picks the most urgent request that is both set and enabled, and it presents that source's 16-bit service address on the vector output. A master enable flag gates the request toward the CPU. The CPU clears this flag with a disable strobe and sets it with an enable strobe or a return-from-interrupt strobe. The flag also drops by itself when the CPU accepts an interrupt, so a nested interrupt cannot be taken. A separate wake output ignores the master flag. It tells the power-control logic that a stopped clock must be restarted.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all enable bits, all request flags and the master enable flag are 0, so irq_o, stop_wake_o and vector_o are 0.
- R2: The high enable byte at address F6h is read/write. Bit 7 is INT0, bit 6 INT1, bit 5 INT2, bit 4 INT3, bit 3 T0, bit 2 T1, bit 1 T2 and bit 0 T3. A 1 enables the source.
- R3: The low enable byte at F4h holds AD in bit 7, WDT in bit 6 and BIT in bit 5, all read/write. Bits 4..0 always read 0, and writes to them have no effect.
- R4: A source pulse sets that source's flag on the next edge. The flags read back at F7h (high byte) and F5h (low byte), with the same bit mapping as the enable bytes. When software writes 0 to a flag bit, the flag clears. When software writes 1, the flag keeps its value. If a pulse arrives in the same cycle as a clear, the pulse wins.
- R5: Priority is fixed, from highest to lowest: INT0, INT1, INT2, INT3, T0, T1, T2, T3, AD, WDT, BIT. Source number k runs from 0 for INT0 to 10 for BIT. For the selected source, vector_o equals VEC_TOP - k*VEC_STEP. When no source is pending and enabled, vector_o is 0.
- R6: irq_o is 1 exactly when the master enable flag is 1 and at least one flag is both set and enabled.
- R7: If ack_i is high while irq_o is high, the next edge clears the selected source's flag and clears the master enable flag. If ack_i is high while irq_o is low, it has no effect.
- R8: di_i clears the master enable flag. Either ei_i or reti_i sets it. When a clear and a set arrive in the same cycle, the clear wins.
- R9: stop_wake_o is 1 exactly when at least one flag is both set and enabled, whatever the master enable flag holds.
- R10: Any address other than F4h..F7h reads 0, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational from address) |
| src_pulse_i | input | 11 | Source pulses, bit k is source k in priority order |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| di_i | input | 1 | Disable-interrupts strobe |
| ei_i | input | 1 | Enable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 16 | Service address of the selected source |
| stop_wake_o | output | 1 | Wake request to the power control |

## Verification
The bench builds the block with its default parameters: the four register addresses F4h..F7h, a vector top of FFFAh and a step of 2. With these values the vectors run from FFFAh for INT0 down to FFE6h for BIT, so every source's vector is compared against an exact constant. Random traffic mixes sparse pulses with register writes, including writes that land on unmapped addresses. It also brings collisions within reach: a pulse and a clear hitting the same flag in one cycle, acknowledges given while irq_o is low, and disable and enable strobes arriving together.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC = 11;
  localparam int NUM_HI  = 8;
  localparam int NUM_LO  = NUM_SRC - NUM_HI;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  localparam src_vec_t HI_MASK = src_vec_t'((1 << NUM_HI) - 1);
  localparam src_vec_t LO_MASK = ~HI_MASK;

  // source k sits at bit (7-k) of the high byte
  function automatic logic [7:0] hi_byte(src_vec_t v);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < NUM_HI; i++) b[7-i] = v[i];
    return b;
  endfunction

  // source NUM_HI+j sits at bit (7-j) of the low byte
  function automatic logic [7:0] lo_byte(src_vec_t v);
    logic [7:0] b;
    b = '0;
    for (int j = 0; j < NUM_LO; j++) b[7-j] = v[NUM_HI+j];
    return b;
  endfunction

  function automatic src_vec_t from_hi(logic [7:0] b);
    src_vec_t v;
    v = '0;
    for (int i = 0; i < NUM_HI; i++) v[i] = b[7-i];
    return v;
  endfunction

  function automatic src_vec_t from_lo(logic [7:0] b);
    src_vec_t v;
    v = '0;
    for (int j = 0; j < NUM_LO; j++) v[NUM_HI+j] = b[7-j];
    return v;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] hw_clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= 1'b0;
      else if (set_i[k])                 q <= 1'b1;  // set beats clear
      else if (sw_clr_i[k] || hw_clr_i[k]) q <= 1'b0;
    end
    assign flag_o[k] = q;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int          N        = 11,
  parameter logic [15:0] VEC_TOP  = 16'hFFFA,
  parameter logic [15:0] VEC_STEP = 16'd2
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [N-1:0] sel_o,
  output logic [15:0]  vector_o
);
  logic [N:0] above;  // above[k]: some higher-priority request exists

  assign above[0] = 1'b0;
  for (genvar k = 0; k < N; k++) begin : g_chain
    assign sel_o[k]   = req_i[k] & ~above[k];
    assign above[k+1] = above[k] | req_i[k];
  end
  assign any_o = above[N];

  always_comb begin
    vector_o = '0;
    for (int k = 0; k < N; k++)
      if (sel_o[k]) vector_o = VEC_TOP - 16'(k) * VEC_STEP;
  end
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic mie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mie_o <= 1'b0;
    else if (clr_i) mie_o <= 1'b0;
    else if (set_i) mie_o <= 1'b1;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import intc_pkg::*;
#(
  parameter logic [7:0]  EN_LO_ADDR = 8'hF4,
  parameter logic [7:0]  FL_LO_ADDR = 8'hF5,
  parameter logic [7:0]  EN_HI_ADDR = 8'hF6,
  parameter logic [7:0]  FL_HI_ADDR = 8'hF7,
  parameter logic [15:0] VEC_TOP    = 16'hFFFA,
  parameter logic [15:0] VEC_STEP   = 16'd2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic               ack_i,
  input  logic               di_i,
  input  logic               ei_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [15:0]        vector_o,
  output logic               stop_wake_o
);
  localparam int N = NUM_SRC;

  src_vec_t en_q, flag_q, pend, sel, sw_clr, hw_clr;
  logic     any_pend, mie, accept;

  logic wr_en_hi, wr_en_lo, wr_fl_hi, wr_fl_lo;
  assign wr_en_hi = bus_wr_i && (bus_addr_i == EN_HI_ADDR);
  assign wr_en_lo = bus_wr_i && (bus_addr_i == EN_LO_ADDR);
  assign wr_fl_hi = bus_wr_i && (bus_addr_i == FL_HI_ADDR);
  assign wr_fl_lo = bus_wr_i && (bus_addr_i == FL_LO_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (wr_en_hi) en_q <= (en_q & ~HI_MASK) | (from_hi(bus_wdata_i) & HI_MASK);
    else if (wr_en_lo) en_q <= (en_q & ~LO_MASK) | (from_lo(bus_wdata_i) & LO_MASK);
  end

  // software may only clear flags: a 0 bit clears, a 1 bit keeps
  always_comb begin
    sw_clr = '0;
    if (wr_fl_hi) sw_clr = HI_MASK & ~from_hi(bus_wdata_i);
    if (wr_fl_lo) sw_clr = LO_MASK & ~from_lo(bus_wdata_i);
  end

  assign accept = ack_i & irq_o;
  assign hw_clr = accept ? sel : '0;

  irq_flag_bank #(.N(N)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (src_pulse_i),
    .sw_clr_i (sw_clr),
    .hw_clr_i (hw_clr),
    .flag_o   (flag_q)
  );

  assign pend = flag_q & en_q;

  irq_prio_sel #(.N(N), .VEC_TOP(VEC_TOP), .VEC_STEP(VEC_STEP)) u_prio (
    .req_i    (pend),
    .any_o    (any_pend),
    .sel_o    (sel),
    .vector_o (vector_o)
  );

  irq_master_en u_mie (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ei_i | reti_i),
    .clr_i  (di_i | accept),
    .mie_o  (mie)
  );

  assign irq_o       = mie & any_pend;
  assign stop_wake_o = any_pend;

  always_comb begin
    unique case (bus_addr_i)
      EN_HI_ADDR: bus_rdata_o = hi_byte(en_q);
      EN_LO_ADDR: bus_rdata_o = lo_byte(en_q);
      FL_HI_ADDR: bus_rdata_o = hi_byte(flag_q);
      FL_LO_ADDR: bus_rdata_o = lo_byte(flag_q);
      default:    bus_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import intc_pkg::*;
#(
  parameter logic [7:0] LO_ADDR = 8'hF4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [7:0]         bus_addr_i,
  input logic [7:0]         bus_rdata_o,
  input logic [NUM_SRC-1:0] src_pulse_i,
  input logic               ack_i,
  input logic               di_i,
  input logic               ei_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [15:0]        vector_o,
  input logic               stop_wake_o,
  input logic               mie,
  input logic [NUM_SRC-1:0] flag_q
);
  AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stop_wake_o);  // R9
  AST_IRQ_NEEDS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mie);  // R6
  AST_ACCEPT_DROPS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !mie);  // R7
  AST_DI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !mie);  // R8
  AST_SET_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ei_i || reti_i) && !di_i && !(ack_i && irq_o)) |=> mie);  // R8
  AST_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_pulse_i) |=> ((flag_q & $past(src_pulse_i)) == $past(src_pulse_i)));  // R4
  AST_NO_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_wake_o |-> (vector_o == 16'h0000));  // R5
  AST_LO_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == LO_ADDR) |-> (bus_rdata_o[4:0] == 5'b0));  // R3
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.LO_ADDR(EN_LO_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .src_pulse_i (src_pulse_i),
  .ack_i       (ack_i),
  .di_i        (di_i),
  .ei_i        (ei_i),
  .reti_i      (reti_i),
  .irq_o       (irq_o),
  .vector_o    (vector_o),
  .stop_wake_o (stop_wake_o),
  .mie         (mie),
  .flag_q      (flag_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 1'b0, ack = 1'b0, di = 1'b0, ei = 1'b0, reti = 1'b0;
  logic [N-1:0] pulse = '0;
  logic [7:0] rdata;
  logic irq, wake;
  logic [15:0] vec;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  logic [N-1:0] m_en = '0, m_fl = '0;
  logic m_mie = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_pulse_i(pulse),
    .ack_i(ack), .di_i(di), .ei_i(ei), .reti_i(reti),
    .irq_o(irq), .vector_o(vec), .stop_wake_o(wake)
  );

  function automatic logic [7:0] m_read(logic [7:0] a);
    logic [7:0] b = '0;
    case (a)
      8'hF6: for (int i = 0; i < 8; i++) b[7-i] = m_en[i];
      8'hF7: for (int i = 0; i < 8; i++) b[7-i] = m_fl[i];
      8'hF4: for (int j = 0; j < 3; j++) b[7-j] = m_en[8+j];
      8'hF5: for (int j = 0; j < 3; j++) b[7-j] = m_fl[8+j];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic int m_sel();
    for (int k = 0; k < N; k++) if (m_fl[k] && m_en[k]) return k;
    return -1;
  endfunction

  function automatic logic [15:0] m_vec();
    int k = m_sel();
    return (k < 0) ? 16'h0000 : 16'(16'hFFFA - 2 * k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic [7:0] a, logic w, logic [7:0] d, logic [N-1:0] p,
                      logic ak, logic dis, logic en, logic rt);
    logic acc;
    int s;
    @(negedge clk);
    addr = a; wr = w; wdata = d; pulse = p; ack = ak; di = dis; ei = en; reti = rt;
    #(CLK_PERIOD/2 - 2);
    s = m_sel();
    chk("R1 R2 R3 R4 R10 rdata", 32'(rdata), 32'(m_read(a)));
    chk("R6 irq", 32'(irq), 32'(m_mie && s >= 0));
    chk("R5 vector", 32'(vec), 32'(m_vec()));
    chk("R9 wake", 32'(wake), 32'(s >= 0));
    acc = ak && m_mie && s >= 0;
    @(posedge clk);
    if (w && a == 8'hF7) for (int i = 0; i < 8; i++) if (!d[7-i]) m_fl[i] = 1'b0;
    if (w && a == 8'hF5) for (int j = 0; j < 3; j++) if (!d[7-j]) m_fl[8+j] = 1'b0;
    if (acc) m_fl[s] = 1'b0;
    m_fl = m_fl | p;
    if (w && a == 8'hF6) for (int i = 0; i < 8; i++) m_en[i] = d[7-i];
    if (w && a == 8'hF4) for (int j = 0; j < 3; j++) m_en[8+j] = d[7-j];
    if (acc || dis) m_mie = 1'b0;
    else if (en || rt) m_mie = 1'b1;
  endtask

  task automatic idle(logic [7:0] a);
    step(a, 1'b0, 8'h00, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 8'hF4; a <= 8'hF7; a++) begin
      @(negedge clk); addr = 8'(a); #1;
      chk("R1 reset rdata", 32'(rdata), 32'h0);
    end
    chk("R1 reset irq/wake/vec", {15'b0, irq, wake, vec}, 32'h0);

    // R3: low enable unused bits
    step(8'hF4, 1'b1, 8'hFF, '0, 0, 0, 0, 0);
    idle(8'hF4);
    chk("R3 low enable readback", 32'(rdata), 32'hE0);
    // R10: unmapped write leaves state
    step(8'h10, 1'b1, 8'hFF, '0, 0, 0, 0, 0);
    idle(8'h10);
    chk("R10 unmapped read", 32'(rdata), 32'h0);
    step(8'hF6, 1'b1, 8'hFF, '0, 0, 0, 1, 0);  // R2, R8 ei
    idle(8'hF6);
    chk("R2 high enable readback", 32'(rdata), 32'hFF);

    // R5/R7: INT0 and BIT pending, INT0 wins then BIT
    step(8'hF7, 1'b0, 8'h00, 11'b100_0000_0001, 0, 0, 0, 0);
    idle(8'hF7);
    chk("R5 INT0 vector", 32'(vec), 32'hFFFA);
    chk("R4 INT0 flag read", 32'(rdata), 32'h80);
    step(8'hF7, 1'b0, 8'h00, '0, 1, 0, 0, 0);  // accept
    idle(8'hF5);
    chk("R7 irq low after accept", 32'(irq), 32'h0);
    chk("R7 INT0 flag cleared, BIT kept", 32'(rdata), 32'h20);
    chk("R5 BIT vector", 32'(vec), 32'hFFE6);
    chk("R9 wake without master", 32'(wake), 32'h1);
    step(8'hF5, 1'b0, 8'h00, '0, 1, 0, 0, 0);  // R7: ack with irq low ignored
    idle(8'hF5);
    chk("R7 ignored ack keeps flag", 32'(rdata), 32'h20);
    step(8'hF5, 1'b0, 8'h00, '0, 0, 1, 0, 1);  // R8: di beats reti
    idle(8'hF5);
    chk("R8 clear wins", 32'(irq), 32'h0);
    step(8'hF5, 1'b1, 8'h00, 11'b100_0000_0000, 0, 0, 0, 1);  // R4: pulse beats clear
    idle(8'hF5);
    chk("R4 pulse wins over clear", 32'(rdata), 32'h20);
    chk("R8 reti sets master", 32'(irq), 32'h1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, d;
      logic [N-1:0] p;
      int r = int'($urandom % 8);
      a = (r < 6) ? 8'(8'hF4 + (r % 4)) : 8'($urandom);
      d = 8'($urandom);
      p = '0;
      for (int k = 0; k < N; k++) p[k] = ($urandom % 12) == 0;
      step(a, ($urandom % 3) == 0, d, p, ($urandom % 4) == 0,
           ($urandom % 16) == 0, ($urandom % 10) == 0, ($urandom % 12) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule